// File: doc/BRIEF.md
# Accumulator Machine Instruction Sequencer

This block is the control and datapath core of a 16-bit accumulator machine. A step counter walks each instruction through numbered timing slots. Slots 0 to 2 fetch and decode the instruction. Slot 3 either resolves an indirect address or hands the instruction to a neighbouring unit. Slots 4 to 6 carry out the memory-reference operations. The core holds the program counter, the address register, the instruction register, the data register, the accumulator, the extend bit and the indirect flag. It also holds a 4096-word by 16-bit memory with a synchronous read port.

An instruction word has three fields. The indirect flag sits at the top, the 3-bit operation code sits under it, and the 12-bit operand address fills the low bits. Operation code 7 is not executed here. The core raises a one-cycle dispatch strobe so that separate register and I/O units can act on that instruction. Those units stop the machine through `halt_req`. The `start` input is the only way to set the machine running again. During reset, a preload port writes the initial program into memory.

Top module: `acc_seq_core`

## Requirements
- R1: An instruction word puts the indirect flag in bit 15, the operation code in bits 14..12 and the operand address in bits 11..0. The codes are: 0 AND, 1 ADD, 2 LDA (load), 3 STA (store), 4 BUN (branch), 5 BSA (branch and save), 6 ISZ (increment and skip if zero), and 7 dispatch to an external unit.
- R2: While `rst_n` is low, the step count, PC, AC and E are cleared and the machine is set running. A write on the preload port (`load_en`) stores `load_data` at `load_addr`, both in reset and out of it, and wins over a core write in the same cycle.
- R3: Each slot lasts one clock. Slot 0 copies PC into AR. Slot 1 loads IR from memory at AR and increments PC. Slot 2 latches the operation code, copies IR bits 11..0 into AR and copies IR bit 15 into the indirect flag. The step count never exceeds 6.
- R4: In slot 3 of a code 0..6 instruction, AR is replaced by bits 11..0 of memory at AR when the indirect flag is 1. When the flag is 0, nothing changes in slot 3. Execution starts in slot 4.
- R5: AND, ADD and LDA read the operand into DR in slot 4. In slot 5 they set AC to AC&DR, to AC+DR or to DR, and the step count returns to 0. ADD puts its carry-out in E. No other operation changes E.
- R6: STA writes AC to memory at AR in slot 4. BUN copies AR into PC in slot 4. Both return the step count to 0.
- R7: BSA writes the zero-extended PC to memory at AR and increments AR in slot 4. In slot 5 it copies AR into PC and returns to step 0.
- R8: ISZ reads the operand into DR in slot 4 and increments DR in slot 5. In slot 6 it writes DR back, increments PC if DR is zero, and returns to step 0.
- R9: For code 7, slot 3 raises `disp_valid` for exactly one cycle with `disp_ind` = bit 15 and `disp_field` = bits 11..0. The step count returns to 0 and PC and AC are unchanged.
- R10: `halt_req` stops the machine. While stopped, the step count and all registers hold their values. `start` sets the machine running again from the same step and wins over `halt_req` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Sets the machine running |
| halt_req | input | 1 | Stops the machine (from the dispatch units) |
| load_en | input | 1 | Preload write strobe |
| load_addr | input | 12 | Preload word address |
| load_data | input | 16 | Preload word |
| pc_o | output | 12 | Program counter |
| ac_o | output | 16 | Accumulator |
| e_o | output | 1 | Extend (carry) bit |
| run_o | output | 1 | Running flag |
| step_o | output | 3 | Current timing slot |
| disp_valid | output | 1 | Code 7 dispatch strobe |
| disp_ind | output | 1 | Bit 15 of the dispatched word |
| disp_field | output | 12 | Bits 11..0 of the dispatched word |

## Verification
The stimulus is a preloaded program that uses every operation code. It includes an ADD that carries into E and one that does not, so the two carry cases are told apart. It includes an indirect ADD and an indirect BUN, which tell pointer following apart from direct addressing. It has one ISZ that wraps to zero and one that does not, so a skip can be told apart from a plain write-back. A BSA call returns through its saved word, and two dispatches differ only in their indirect bit and field. A halt in the middle of the run, followed by a start raised together with a halt, shows that the machine freezes and then resumes.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    OP_AND = 3'd0, OP_ADD = 3'd1, OP_LDA = 3'd2, OP_STA = 3'd3,
    OP_BUN = 3'd4, OP_BSA = 3'd5, OP_ISZ = 3'd6, OP_EXT = 3'd7
  } op_e;

  // sum with carry-out in the top bit
  function automatic logic [WORD_W:0] add_cy(input logic [WORD_W-1:0] a,
                                             input logic [WORD_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [WORD_W-1:0] bump(input logic [WORD_W-1:0] a);
    return a + 1'b1;
  endfunction
endpackage

// File: rtl/acc_seq_dec.sv
module acc_seq_dec #(
  parameter int SEL_W = 3
) (
  input  logic [SEL_W-1:0]        sel,
  output logic [(1<<SEL_W)-1:0]   hot
);
  for (genvar i = 0; i < (1 << SEL_W); i++) begin : g_line
    assign hot[i] = (sel == SEL_W'(i));
  end
endmodule

// File: rtl/acc_seq_mem.sv
module acc_seq_mem #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  // write-first: a read of the word being written returns the new value
  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    if (we && waddr == raddr) rdata <= wdata;
    else                      rdata <= cells[raddr];
  end
endmodule

// File: rtl/acc_seq_timer.sv
module acc_seq_timer #(
  parameter int STEP_W = 3,
  parameter int LAST   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              halt_req,
  input  logic              clr,
  output logic              run,
  output logic [STEP_W-1:0] step,
  output logic [LAST:0]     hot
);
  always_ff @(posedge clk) begin
    if (!rst_n)        run <= 1'b1;
    else if (start)    run <= 1'b1;
    else if (halt_req) run <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   step <= '0;
    else if (run) step <= clr ? '0 : step + 1'b1;
  end

  for (genvar i = 0; i <= LAST; i++) begin : g_slot
    assign hot[i] = (step == STEP_W'(i));
  end

  p_step_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step <= STEP_W'(LAST));
  p_stop_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(step));
  p_start_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> run);
endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core #(
  parameter int ADDR_W = 12,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              halt_req,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [15:0]       load_data,
  output logic [ADDR_W-1:0] pc_o,
  output logic [15:0]       ac_o,
  output logic              e_o,
  output logic              run_o,
  output logic [STEP_W-1:0] step_o,
  output logic              disp_valid,
  output logic              disp_ind,
  output logic [ADDR_W-1:0] disp_field
);
  import acc_seq_pkg::*;

  localparam int W       = WORD_W;
  localparam int LAST    = 6;
  localparam int IND_BIT = W - 1;
  localparam int OP_HI   = W - 2;
  localparam int OP_LO   = W - 4;
  localparam int NOPS    = 1 << (OP_HI - OP_LO + 1);

  logic [ADDR_W-1:0] pc_q, ar_q, ar_d;
  logic [W-1:0]      ir_q, dr_q, ac_q, rdata, core_wdata;
  logic              e_q, ind_q;
  logic [NOPS-1:0]   d_q, d_dec;
  logic              run, step_clr, core_we;
  logic [STEP_W-1:0] sc;
  logic [LAST:0]     t;

  acc_seq_timer #(.STEP_W(STEP_W), .LAST(LAST)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .halt_req(halt_req),
    .clr(step_clr), .run(run), .step(sc), .hot(t));

  acc_seq_dec #(.SEL_W(OP_HI - OP_LO + 1)) u_dec (
    .sel(ir_q[OP_HI:OP_LO]), .hot(d_dec));

  // named events, one per register transfer
  logic ev_addr, ev_fetch, ev_decode, ev_ind, ev_disp, ev_rd_op;
  logic ev_sta, ev_bun, ev_bsa_save, ev_bsa_jump;
  logic ev_and, ev_add, ev_lda, ev_isz_inc, ev_isz_wb, isz_skip;

  assign ev_addr     = run & t[0];
  assign ev_fetch    = run & t[1];
  assign ev_decode   = run & t[2];
  assign ev_ind      = run & t[3] & ~d_q[OP_EXT] & ind_q;
  assign ev_disp     = run & t[3] &  d_q[OP_EXT];
  assign ev_rd_op    = run & t[4] & (d_q[OP_AND] | d_q[OP_ADD] | d_q[OP_LDA] | d_q[OP_ISZ]);
  assign ev_sta      = run & t[4] & d_q[OP_STA];
  assign ev_bun      = run & t[4] & d_q[OP_BUN];
  assign ev_bsa_save = run & t[4] & d_q[OP_BSA];
  assign ev_bsa_jump = run & t[5] & d_q[OP_BSA];
  assign ev_and      = run & t[5] & d_q[OP_AND];
  assign ev_add      = run & t[5] & d_q[OP_ADD];
  assign ev_lda      = run & t[5] & d_q[OP_LDA];
  assign ev_isz_inc  = run & t[5] & d_q[OP_ISZ];
  assign ev_isz_wb   = run & t[6] & d_q[OP_ISZ];
  assign isz_skip    = ev_isz_wb & (dr_q == '0);

  assign step_clr = ev_disp | ev_sta | ev_bun | ev_bsa_jump |
                    ev_and | ev_add | ev_lda | ev_isz_wb;

  assign core_we    = ev_sta | ev_bsa_save | ev_isz_wb;
  assign core_wdata = ev_sta      ? ac_q :
                      ev_bsa_save ? {{(W-ADDR_W){1'b0}}, pc_q} : dr_q;

  // next AR also addresses the read port, so rdata always shows M[AR]
  always_comb begin
    ar_d = ar_q;
    if (ev_addr)          ar_d = pc_q;
    else if (ev_decode)   ar_d = ir_q[ADDR_W-1:0];
    else if (ev_ind)      ar_d = rdata[ADDR_W-1:0];
    else if (ev_bsa_save) ar_d = ar_q + 1'b1;
  end

  acc_seq_mem #(.AW(ADDR_W), .DW(W)) u_mem (
    .clk(clk),
    .we(load_en | core_we),
    .waddr(load_en ? load_addr : ar_q),
    .wdata(load_en ? load_data : core_wdata),
    .raddr(ar_d),
    .rdata(rdata));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0; ar_q <= '0; ir_q <= '0; dr_q <= '0;
      ac_q <= '0; e_q <= 1'b0; ind_q <= 1'b0; d_q <= '0;
    end else begin
      ar_q <= ar_d;
      if (ev_fetch) ir_q <= rdata;
      if (ev_decode) begin
        d_q   <= d_dec;
        ind_q <= ir_q[IND_BIT];
      end
      if (ev_fetch || isz_skip)      pc_q <= pc_q + 1'b1;
      else if (ev_bun || ev_bsa_jump) pc_q <= ar_q;
      if (ev_rd_op)        dr_q <= rdata;
      else if (ev_isz_inc) dr_q <= bump(dr_q);
      if (ev_and)      ac_q <= ac_q & dr_q;
      else if (ev_lda) ac_q <= dr_q;
      else if (ev_add) {e_q, ac_q} <= add_cy(ac_q, dr_q);
    end
  end

  assign pc_o       = pc_q;
  assign ac_o       = ac_q;
  assign e_o        = e_q;
  assign run_o      = run;
  assign step_o     = sc;
  assign disp_valid = ev_disp;
  assign disp_ind   = ind_q;
  assign disp_field = ir_q[ADDR_W-1:0];

  p_addr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr |=> ar_q == $past(pc_q));
  p_fetch_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch |=> pc_q == ADDR_W'($past(pc_q) + 1'b1));
  p_direct_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && t[3] && !d_q[OP_EXT] && !ind_q) |=> $stable(ar_q) && $stable(pc_q));
  p_e_only_add_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_add |=> $stable(e_q));
  p_write_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    core_we |-> (sc == STEP_W'(4) || sc == STEP_W'(6)));
  p_bun_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bun |=> pc_q == $past(ar_q) && sc == '0);
  p_disp_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_disp |=> sc == '0 && $stable(ac_q) && $stable(pc_q) && !disp_valid);
  p_stopped_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pc_q) && $stable(ac_q) && $stable(ar_q) && $stable(dr_q));
endmodule

// File: tb/acc_seq_core_test.sv
module acc_seq_core_test;
  logic clk = 1'b0;
  logic rst_n, start, halt_req, load_en;
  logic [11:0] load_addr;
  logic [15:0] load_data;
  logic [11:0] pc_o, disp_field;
  logic [15:0] ac_o;
  logic e_o, run_o, disp_valid, disp_ind;
  logic [2:0] step_o;

  always #2 clk = ~clk;

  acc_seq_core uut (
    .clk(clk), .rst_n(rst_n), .start(start), .halt_req(halt_req),
    .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
    .pc_o(pc_o), .ac_o(ac_o), .e_o(e_o), .run_o(run_o), .step_o(step_o),
    .disp_valid(disp_valid), .disp_ind(disp_ind), .disp_field(disp_field));

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model state
  logic [11:0] m_pc, m_ar;
  logic [15:0] m_ir, m_dr, m_ac;
  logic [2:0]  m_op;
  logic        m_e, m_i, m_run;
  int          m_step;
  string       m_tag;
  logic [15:0] mm [0:4095];

  int disp_n = 0;
  logic [11:0] df [0:3];
  logic        dind [0:3];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [15:0] rd;
    logic [16:0] s;
    int nxt;
    if (!rst_n) begin
      m_pc = 0; m_ar = 0; m_ir = 0; m_dr = 0; m_ac = 0; m_op = 0;
      m_e = 0; m_i = 0; m_run = 1; m_step = 0; m_tag = "R2";
    end else begin
      rd = mm[m_ar];
      nxt = m_step + 1;
      m_tag = "R3";
      if (!m_run) m_tag = "R10";
      else begin
        case (m_step)
          0: m_ar = m_pc;
          1: begin m_ir = rd; m_pc = m_pc + 1; end
          2: begin m_op = m_ir[14:12]; m_ar = m_ir[11:0]; m_i = m_ir[15]; end
          3: if (m_op == 3'd7) begin nxt = 0; m_tag = "R9"; end
             else begin m_tag = "R4"; if (m_i) m_ar = rd[11:0]; end
          4: case (m_op)
               3'd3: begin mm[m_ar] = m_ac; nxt = 0; m_tag = "R6"; end
               3'd4: begin m_pc = m_ar; nxt = 0; m_tag = "R6"; end
               3'd5: begin mm[m_ar] = {4'h0, m_pc}; m_ar = m_ar + 1; m_tag = "R7"; end
               3'd6: begin m_dr = rd; m_tag = "R8"; end
               default: begin m_dr = rd; m_tag = "R5"; end
             endcase
          5: case (m_op)
               3'd0: begin m_ac = m_ac & m_dr; nxt = 0; m_tag = "R5"; end
               3'd1: begin s = {1'b0, m_ac} + {1'b0, m_dr}; m_ac = s[15:0]; m_e = s[16];
                           nxt = 0; m_tag = "R5"; end
               3'd2: begin m_ac = m_dr; nxt = 0; m_tag = "R5"; end
               3'd5: begin m_pc = m_ar; nxt = 0; m_tag = "R7"; end
               default: begin m_dr = m_dr + 1; m_tag = "R8"; end
             endcase
          default: begin
            mm[m_ar] = m_dr;
            if (m_dr == 16'h0) m_pc = m_pc + 1;
            nxt = 0; m_tag = "R8";
          end
        endcase
        m_step = nxt;
      end
      if (start) m_run = 1;
      else if (halt_req) m_run = 0;
    end
    if (load_en) mm[load_addr] = load_data;
  endtask

  task automatic compare();
    bit ev;
    ev = m_run && m_step == 3 && m_op == 3'd7;
    chk(pc_o == m_pc, m_tag, "pc", pc_o, m_pc);
    chk(ac_o == m_ac, m_tag, "ac", ac_o, m_ac);
    chk(e_o == m_e, m_tag, "e", e_o, m_e);
    chk(run_o == m_run, m_tag, "run", run_o, m_run);
    chk(int'(step_o) == m_step, m_tag, "step", step_o, m_step);
    chk(disp_valid == ev, "R9", "disp_valid", disp_valid, ev);
    if (ev) begin
      chk(disp_ind == m_i, "R9", "disp_ind", disp_ind, m_i);
      chk(disp_field == m_ir[11:0], "R9", "disp_field", disp_field, m_ir[11:0]);
    end
    if (disp_valid && disp_n < 4) begin
      df[disp_n] = disp_field; dind[disp_n] = disp_ind;
    end
    if (disp_valid) disp_n++;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic preload(input logic [11:0] a, input logic [15:0] d);
    load_en = 1; load_addr = a; load_data = d;
    cyc();
    load_en = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4096; k++) mm[k] = 16'h0;
    rst_n = 0; start = 0; halt_req = 0; load_en = 0; load_addr = 0; load_data = 0;
    @(negedge clk);
    cyc();
    // program: exercises every operation code (R1 field layout)
    preload(12'h000, 16'h2100);  // LDA 100
    preload(12'h001, 16'h1102);  // ADD 102, carry out
    preload(12'h002, 16'h0101);  // AND 101
    preload(12'h003, 16'h9104);  // ADD indirect via 104
    preload(12'h004, 16'h3106);  // STA 106
    preload(12'h005, 16'h6102);  // ISZ 102, wraps -> skip
    preload(12'h006, 16'h2100);  // skipped
    preload(12'h007, 16'h6103);  // ISZ 103, no skip
    preload(12'h008, 16'h5110);  // BSA 110
    preload(12'h009, 16'h2103);  // LDA 103
    preload(12'h00A, 16'h400A);  // BUN self
    preload(12'h100, 16'h00F0);
    preload(12'h101, 16'h0F0F);
    preload(12'h102, 16'hFFFF);
    preload(12'h103, 16'h0001);
    preload(12'h104, 16'h0103);
    preload(12'h111, 16'h2106);  // LDA 106
    preload(12'h112, 16'h7800);  // dispatch, direct
    preload(12'h113, 16'hF400);  // dispatch, indirect bit set
    preload(12'h114, 16'hC110);  // BUN indirect via 110
    // R2: state held in reset
    chk(pc_o == 0 && ac_o == 0 && !e_o && step_o == 0, "R2", "reset regs",
        {pc_o, ac_o[3:0]}, 0);
    chk(run_o == 1'b1, "R2", "reset run", run_o, 1);
    rst_n = 1;
    repeat (60) cyc();
    // R10: halt, freeze, resume with start winning over halt_req
    halt_req = 1; cyc(); halt_req = 0;
    begin
      logic [2:0] st; logic [11:0] p;
      st = step_o; p = pc_o;
      repeat (6) cyc();
      chk(run_o == 1'b0, "R10", "stopped", run_o, 0);
      chk(step_o == st && pc_o == p, "R10", "frozen step", step_o, st);
    end
    start = 1; halt_req = 1; cyc(); start = 0; halt_req = 0;
    chk(run_o == 1'b1, "R10", "start priority", run_o, 1);
    repeat (140) cyc();
    // R9 and R1: two dispatches with their fields
    chk(disp_n == 2, "R9", "dispatch count", disp_n, 2);
    chk(df[0] == 12'h800 && dind[0] == 1'b0, "R1", "first dispatch", {dind[0], df[0]}, 12'h800);
    chk(df[1] == 12'h400 && dind[1] == 1'b1, "R1", "second dispatch", {dind[1], df[1]}, 13'h1400);
    chk(ac_o == 16'h0002, "R8", "ISZ result loaded", ac_o, 2);
    chk(e_o == 1'b0, "R5", "E after second ADD", e_o, 0);
    for (int k = 0; k < 10 && step_o != 0; k++) cyc();
    chk(pc_o == 12'h00A, "R6", "branch loop pc", pc_o, 10);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule